// File: doc/BRIEF.md
# Adaptive Data Slicer Level Tracker

This block turns filtered, signed baseband samples from a frequency-discriminator receive path into data bits. A sample value of zero stands for the mid-supply level. Two separate registers follow the signal. One follows the height of the excursions above mid level and the other follows the depth of the excursions below it. The decision threshold is the midpoint of the two tracked levels, so it moves with both the received amplitude and any standing DC offset. On each bit-centre strobe from the external clock recovery, the current sample is compared against this threshold and becomes one data bit. The polarity is inverted: a sample above the threshold gives 0.

A small mode state machine sets how the trackers behave. It has three states. MODE_ACQ moves the levels quickly while a preamble arrives. MODE_TRACK follows slowly during normal reception. MODE_FREEZE holds both levels unchanged during a fade, and slicing goes on during MODE_FREEZE. Transitions are evaluated on every clock from the two control inputs. Transition T_ACQ goes from any state to MODE_ACQ when acquire is high. Transition T_HOLD goes from any state to MODE_FREEZE when acquire is low and hold_n is low. Transition T_RUN goes from any state to MODE_TRACK when acquire is low and hold_n is high. After a long fade, a burst of acquire strobes rebuilds the levels.

Top module: `slicer_level_tracker`

## Requirements
- R1: While rst_ni is low, and at the first clock edge after it rises, pos_level_o, neg_level_o, thresh_o and data_o are 0, and the mode is MODE_TRACK.
- R2: On a strobe edge outside MODE_FREEZE with sample s > 0, pos_level_o becomes p + ((s - p) >>> k). Here k is FAST_SHIFT (2) in MODE_ACQ and SLOW_SHIFT (6) in MODE_TRACK, and the shift is an arithmetic shift with floor rounding. A sample s <= 0 leaves pos_level_o unchanged.
- R3: On a strobe edge outside MODE_FREEZE with sample s < 0, neg_level_o becomes n + ((s - n) >>> k), with the same k as in R2. A sample s >= 0 leaves neg_level_o unchanged.
- R4: thresh_o always equals (pos_level_o + neg_level_o) >>> 1, computed in signed arithmetic with floor rounding. It therefore lies between the two levels.
- R5: On a strobe edge, data_o is loaded with 0 if the sample is greater than the threshold in force before that edge, and with 1 otherwise. A sample equal to the threshold gives 1.
- R6: The mode register takes the control inputs at each clock edge and affects strobes from the next edge on. acquire high selects MODE_ACQ whatever the value of hold_n. acquire low with hold_n low selects MODE_FREEZE. Otherwise the mode is MODE_TRACK.
- R7: In MODE_FREEZE, strobes leave both levels unchanged, and data_o is still sliced as in R5.
- R8: Without a strobe, levels and data_o keep their values whatever the sample and control inputs do.
- R9: Starting from levels of the correct sign and no larger than A, 16 acquire strobes alternating +A and -A bring each level to within A/8 of its target. The bench checks this with A = 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | W (12) | Signed filtered sample, 0 = mid level |
| strobe_i | input | 1 | Bit-centre strobe, one cycle |
| acq_i | input | 1 | Fast acquisition request |
| hold_ni | input | 1 | Low freezes levels while acq_i is low |
| data_o | output | 1 | Sliced bit (above threshold = 0) |
| pos_level_o | output | W (12) | Tracked positive excursion level |
| neg_level_o | output | W (12) | Tracked negative excursion level |
| thresh_o | output | W (12) | Current decision threshold |

## Verification
A wrong level register shows up at the level outputs right after the strobe edge that produced it. The threshold is combinational from the levels, so the same fault is also visible on thresh_o and, from the next strobe on, can flip data_o. A wrong mode shows up one strobe later, because the levels then move by the wrong step or fail to freeze. Comparing every strobe against a step-by-step model exposes such errors within one bit period.

// File: rtl/slt_pkg.sv
package slt_pkg;
    typedef enum logic [1:0] {
        MODE_TRACK  = 2'd0,
        MODE_ACQ    = 2'd1,
        MODE_FREEZE = 2'd2
    } mode_e;
endpackage

// File: rtl/slt_mode_fsm.sv
module slt_mode_fsm
    import slt_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  acq_i,
    input  logic  hold_ni,
    output mode_e mode_o,
    output logic  upd_en_o,
    output logic  fast_o
);
    mode_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= MODE_TRACK;
        else         state_q <= state_d;
    end

    // T_ACQ, T_HOLD and T_RUN are reachable from every state
    always_comb begin
        if (acq_i)         state_d = MODE_ACQ;
        else if (!hold_ni) state_d = MODE_FREEZE;
        else               state_d = MODE_TRACK;
    end

    always_comb begin
        upd_en_o = 1'b0;
        fast_o   = 1'b0;
        unique case (state_q)
            MODE_TRACK:  upd_en_o = 1'b1;
            MODE_ACQ: begin
                upd_en_o = 1'b1;
                fast_o   = 1'b1;
            end
            MODE_FREEZE: upd_en_o = 1'b0;
            default:     upd_en_o = 1'b0;
        endcase
    end

    assign mode_o = state_q;
endmodule

// File: rtl/slt_peak_tracker.sv
module slt_peak_tracker #(
    parameter int W          = 12,
    parameter bit POSITIVE   = 1'b1,
    parameter int FAST_SHIFT = 2,
    parameter int SLOW_SHIFT = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                strobe_i,
    input  logic                upd_en_i,
    input  logic                fast_i,
    input  logic signed [W-1:0] sample_i,
    output logic signed [W-1:0] level_o
);
    localparam int MAXSH = (FAST_SHIFT > SLOW_SHIFT) ? FAST_SHIFT : SLOW_SHIFT;
    localparam int SHW   = $clog2(MAXSH + 1);

    logic signed [W-1:0] level_q;
    logic signed [W:0]   diff, step, nxt;
    logic [SHW-1:0]      shamt;
    logic                qual;

    generate
        if (POSITIVE) begin : g_pos
            assign qual = !sample_i[W-1] && (sample_i != '0);
        end else begin : g_neg
            assign qual = sample_i[W-1];
        end
    endgenerate

    assign shamt = fast_i ? SHW'(FAST_SHIFT) : SHW'(SLOW_SHIFT);
    assign diff  = {sample_i[W-1], sample_i} - {level_q[W-1], level_q};
    assign step  = diff >>> shamt;
    assign nxt   = {level_q[W-1], level_q} + step;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           level_q <= '0;
        else if (strobe_i && upd_en_i && qual) level_q <= nxt[W-1:0];
    end

    assign level_o = level_q;
endmodule

// File: rtl/slt_slicer.sv
module slt_slicer #(
    parameter int W = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                strobe_i,
    input  logic signed [W-1:0] sample_i,
    input  logic signed [W-1:0] pos_i,
    input  logic signed [W-1:0] neg_i,
    output logic signed [W-1:0] thresh_o,
    output logic                data_o
);
    logic signed [W:0] sum, half;
    logic              data_q;

    assign sum      = {pos_i[W-1], pos_i} + {neg_i[W-1], neg_i};
    assign half     = sum >>> 1;
    assign thresh_o = half[W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       data_q <= 1'b0;
        else if (strobe_i) data_q <= (sample_i > thresh_o) ? 1'b0 : 1'b1;
    end

    assign data_o = data_q;
endmodule

// File: rtl/slicer_level_tracker.sv
module slicer_level_tracker
    import slt_pkg::*;
#(
    parameter int W          = 12,
    parameter int FAST_SHIFT = 2,
    parameter int SLOW_SHIFT = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic signed [W-1:0] sample_i,
    input  logic                strobe_i,
    input  logic                acq_i,
    input  logic                hold_ni,
    output logic                data_o,
    output logic signed [W-1:0] pos_level_o,
    output logic signed [W-1:0] neg_level_o,
    output logic signed [W-1:0] thresh_o
);
    mode_e mode_q;
    logic  upd_en, fast;

    slt_mode_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .acq_i    (acq_i),
        .hold_ni  (hold_ni),
        .mode_o   (mode_q),
        .upd_en_o (upd_en),
        .fast_o   (fast)
    );

    slt_peak_tracker #(.W(W), .POSITIVE(1'b1),
                       .FAST_SHIFT(FAST_SHIFT), .SLOW_SHIFT(SLOW_SHIFT)) u_pos (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .upd_en_i (upd_en),
        .fast_i   (fast),
        .sample_i (sample_i),
        .level_o  (pos_level_o)
    );

    slt_peak_tracker #(.W(W), .POSITIVE(1'b0),
                       .FAST_SHIFT(FAST_SHIFT), .SLOW_SHIFT(SLOW_SHIFT)) u_neg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .upd_en_i (upd_en),
        .fast_i   (fast),
        .sample_i (sample_i),
        .level_o  (neg_level_o)
    );

    slt_slicer #(.W(W)) u_slice (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .sample_i (sample_i),
        .pos_i    (pos_level_o),
        .neg_i    (neg_level_o),
        .thresh_o (thresh_o),
        .data_o   (data_o)
    );
endmodule

// File: rtl/slt_checker.sv
module slt_checker
    import slt_pkg::*;
#(
    parameter int W = 12
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                strobe_i,
    input logic                acq_i,
    input logic signed [W-1:0] sample_i,
    input logic                data_o,
    input logic signed [W-1:0] pos_level_o,
    input logic signed [W-1:0] neg_level_o,
    input logic signed [W-1:0] thresh_o,
    input mode_e               mode_q
);
    // R1: state right after reset release
    a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (pos_level_o == '0 && neg_level_o == '0 && !data_o && mode_q == MODE_TRACK));

    // R2 / R3: each level keeps its own sign
    a_r2_pos_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pos_level_o[W-1]);
    a_r3_neg_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        neg_level_o[W-1] || neg_level_o == '0);

    // R4: threshold lies between the levels
    a_r4_thresh_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thresh_o <= pos_level_o && thresh_o >= neg_level_o);

    // R5: inverted slice against the threshold before the edge
    a_r5_slice_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i |=> data_o == ($past(sample_i) <= $past(thresh_o)));

    // R6: acquire wins over hold
    a_r6_acq_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acq_i |=> mode_q == MODE_ACQ);

    // R7: frozen levels stay put
    a_r7_freeze_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_q == MODE_FREEZE |=> $stable(pos_level_o) && $stable(neg_level_o));

    // R8: nothing moves without a strobe
    a_r8_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(pos_level_o) && $stable(neg_level_o) && $stable(data_o));
endmodule

bind slicer_level_tracker slt_checker #(.W(W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .acq_i       (acq_i),
    .sample_i    (sample_i),
    .data_o      (data_o),
    .pos_level_o (pos_level_o),
    .neg_level_o (neg_level_o),
    .thresh_o    (thresh_o),
    .mode_q      (mode_q)
);

// File: tb/sim_slicer_level_tracker.sv
`timescale 1ns/1ps
module sim_slicer_level_tracker;
    localparam int W = 12;

    logic                clk = 1'b0;
    logic                rst_ni = 1'b0;
    logic signed [W-1:0] sample_i = '0;
    logic                strobe_i = 1'b0;
    logic                acq_i = 1'b0;
    logic                hold_ni = 1'b1;
    logic                data_o;
    logic signed [W-1:0] pos_level_o, neg_level_o, thresh_o;

    int tests = 0;
    int fails = 0;
    int m_pos = 0, m_neg = 0, m_data = 0;
    bit m_acq = 0, m_holdn = 1;

    always #2 clk = ~clk;

    slicer_level_tracker #(.W(W)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .strobe_i(strobe_i),
        .acq_i(acq_i), .hold_ni(hold_ni), .data_o(data_o),
        .pos_level_o(pos_level_o), .neg_level_o(neg_level_o), .thresh_o(thresh_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int move(input int lvl, input int s, input int sh);
        return lvl + ((s - lvl) >>> sh);
    endfunction

    function automatic int m_thr();
        return (m_pos + m_neg) >>> 1;
    endfunction

    task automatic set_mode(input bit acq, input bit holdn);
        @(negedge clk);
        acq_i = acq; hold_ni = holdn;
        m_acq = acq; m_holdn = holdn;
        @(negedge clk);
    endtask

    task automatic strobe(input int s, input string tag_lvl, input string tag_dat);
        int sh;
        sh = m_acq ? 2 : 6;
        m_data = (s > m_thr()) ? 0 : 1;
        if (m_acq || m_holdn) begin
            if (s > 0) m_pos = move(m_pos, s, sh);
            if (s < 0) m_neg = move(m_neg, s, sh);
        end
        @(negedge clk);
        sample_i = W'(s); strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        check(int'(pos_level_o) == m_pos, {tag_lvl, " pos"}, int'(pos_level_o), m_pos);
        check(int'(neg_level_o) == m_neg, {tag_lvl, " neg"}, int'(neg_level_o), m_neg);
        check(int'(thresh_o) == m_thr(), "R4 thresh", int'(thresh_o), m_thr());
        check(int'(data_o) == m_data, tag_dat, int'(data_o), m_data);
    endtask

    task automatic t_reset();
        check(pos_level_o == '0, "R1 pos in reset", int'(pos_level_o), 0);
        check(neg_level_o == '0, "R1 neg in reset", int'(neg_level_o), 0);
        check(thresh_o == '0, "R1 thresh in reset", int'(thresh_o), 0);
        check(data_o == 1'b0, "R1 data in reset", int'(data_o), 0);
        @(negedge clk); rst_ni = 1'b1;
        @(negedge clk);
        check(pos_level_o == '0 && neg_level_o == '0, "R1 after release", int'(pos_level_o), 0);
    endtask

    task automatic t_acquire();
        set_mode(1, 1);
        for (int i = 0; i < 6; i++) begin
            strobe(800, "R2 acq", "R5 acq pos");
            strobe(-800, "R3 acq", "R5 acq neg");
        end
    endtask

    task automatic t_track_offset();
        set_mode(0, 1);
        for (int i = 0; i < 8; i++) begin
            strobe(1500, "R2 track", "R5 offset hi");
            strobe(-500, "R3 track", "R5 offset lo");
            strobe(0, "R2 zero sample", "R5 zero");
        end
        strobe(m_thr(), "R2 at threshold", "R5 equal gives 1");
        check(data_o == 1'b1, "R5 equal threshold", int'(data_o), 1);
        strobe(m_thr() + 1, "R2 above threshold", "R5 above gives 0");
        check(data_o == 1'b0, "R5 one above", int'(data_o), 0);
    endtask

    task automatic t_freeze();
        int p0, n0;
        set_mode(0, 0);
        p0 = int'(pos_level_o); n0 = int'(neg_level_o);
        strobe(2000, "R7 freeze", "R7 slice while frozen hi");
        strobe(-2000, "R7 freeze", "R7 slice while frozen lo");
        check(int'(pos_level_o) == p0, "R7 pos held", int'(pos_level_o), p0);
        check(int'(neg_level_o) == n0, "R7 neg held", int'(neg_level_o), n0);
    endtask

    task automatic t_hold_ignored();
        set_mode(1, 0);
        strobe(1200, "R6 hold ignored in acq", "R5 acq hold");
        strobe(-1200, "R6 hold ignored in acq", "R5 acq hold");
    endtask

    task automatic t_no_strobe();
        int p0, n0, d0;
        p0 = int'(pos_level_o); n0 = int'(neg_level_o); d0 = int'(data_o);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            sample_i = W'((i % 2 == 0) ? 1900 : -1900);
            acq_i = i[0]; hold_ni = ~i[1];
        end
        @(negedge clk);
        check(int'(pos_level_o) == p0, "R8 pos idle", int'(pos_level_o), p0);
        check(int'(neg_level_o) == n0, "R8 neg idle", int'(neg_level_o), n0);
        check(int'(data_o) == d0, "R8 data idle", int'(data_o), d0);
    endtask

    task automatic t_reacquire();
        set_mode(0, 1);
        for (int i = 0; i < 20; i++) begin
            strobe(400, "R2 pre-fade", "R5 pre-fade");
            strobe(-400, "R3 pre-fade", "R5 pre-fade");
        end
        set_mode(0, 0);
        strobe(1000, "R7 fade", "R7 fade slice");
        set_mode(1, 1);
        for (int i = 0; i < 8; i++) begin
            strobe(1000, "R9 reacq", "R5 reacq");
            strobe(-1000, "R9 reacq", "R5 reacq");
        end
        check(pos_level_o >= 875 && pos_level_o <= 1000, "R9 pos within A/8", int'(pos_level_o), 1000);
        check(neg_level_o <= -875 && neg_level_o >= -1000, "R9 neg within A/8", int'(neg_level_o), -1000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_acquire();
        t_track_offset();
        t_freeze();
        t_hold_ignored();
        t_no_strobe();
        set_mode(m_acq, m_holdn);
        t_reacquire();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule